// File: doc/BRIEF.md
# Multirate Link Reconfiguration Sequencer

This block is the control sequencer that brings a serial video receive path up at whatever link rate arrives. Running on a stable management clock, it first holds the receive clock generator and the receive lane in reset. It then counts rising edges of the incoming link reference clock over a fixed gate window and sorts the count into a frequency band. It compares that band, and the current color depth, with the settings it committed on its previous pass, and only then asks an external reconfiguration engine to reprogram the clock generator, the lane, or both.

Each reprogramming request is a level-held handshake that waits for an acknowledge, and a timeout sends the sequence back to its start. Once programming is finished, or was not needed, the resets are held for a short settle time and then released together. The block waits for every lock indicator to come up and then sits in a steady state. There it re-measures the link clock at a fixed interval, and it restarts the whole sequence when the band moves or when any lock indicator drops. The block also selects oversampling mode for slow links, which the lane uses to force its clock recovery into lock-to-reference operation.

Top module: `rate_reconfig_seq`

## Requirements
- R1: While `rst_mgmt_n` is low, and right after it rises, `pll_rst` and `lane_rst` are 1, both request outputs are 0 and `oversample_en` is 0.
- R2: A reconfiguration request is only ever raised while both reset outputs are asserted.
- R3: The band is the number of entries of `BAND_EDGES` (32-bit entries, entry 0 in the least significant bits, increasing values) that the count of link clock rising edges over `GATE_CYCLES` management cycles reaches or exceeds. The committed band is shown on `cfg_band` and the committed depth on `cfg_depth`.
- R4: The first pass after reset requests both clock generator and lane reprogramming, whatever the band.
- R5: On later passes the clock generator is requested when the band or the color depth differs from the committed values, and the lane only when the band differs. A change of depth alone with the same band requests the clock generator only. When both are needed, the clock generator request comes first and the two are never high together.
- R6: A pass in which neither band nor depth has changed raises no request and still asserts and then releases the resets.
- R7: A request stays high until its acknowledge is seen and is low in the cycle after the acknowledge.
- R8: If no acknowledge arrives within `TIMEOUT` cycles, the request drops, the resets stay asserted, the sequence restarts and the committed settings are forgotten, so the next pass requests both.
- R9: After the last request is acknowledged (or none was made), both resets stay asserted for at least `RST_CYCLES` more cycles and are released in the same cycle.
- R10: In steady state, a low on `pll_locked`, `lane_locked` or `core_locked` asserts both resets in the next cycle and restarts the sequence.
- R11: In steady state the link clock is re-measured every `RUN_INTERVAL` cycles. The same band leaves the resets released. A different band restarts the sequence.
- R12: `oversample_en` is 1 exactly when the committed band is below `OVS_BANDS`, and it only changes while the resets are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mgmt | input | 1 | Stable management clock |
| rst_mgmt_n | input | 1 | Asynchronous active-low reset |
| link_clk | input | 1 | Incoming link reference clock being measured |
| pll_locked | input | 1 | Clock generator lock status |
| lane_locked | input | 1 | Receive lane lock status |
| core_locked | input | 1 | Protocol core lock status |
| color_depth | input | DEPTH_W | Current color depth code |
| pll_cfg_req | output | 1 | Clock generator reprogramming request (level) |
| pll_cfg_ack | input | 1 | Clock generator reprogramming done |
| lane_cfg_req | output | 1 | Lane reprogramming request (level) |
| lane_cfg_ack | input | 1 | Lane reprogramming done |
| pll_rst | output | 1 | Reset to the receive clock generator |
| lane_rst | output | 1 | Reset to the receive lane |
| cfg_band | output | BW | Committed frequency band |
| cfg_depth | output | DEPTH_W | Committed color depth |
| oversample_en | output | 1 | Oversampling mode select (lock-to-reference control) |

## Verification
The hardest situations to reach from the ports are a band change seen by the periodic re-measurement with every lock still high, and a pass that repeats the committed band but must still reprogram because a timeout erased the stored settings. The bench drives a real asynchronous link clock whose period it retunes while the block is in steady state, and it simply waits for the interval measurement to find the new band. For the timeout, it holds back the acknowledge on a pass that has already committed its band, then answers the following pass and expects both requests again. A change of color depth with the link clock unchanged checks that depth is compared separately from the band.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic [3:0] {
    ST_HOLD,       // resets asserted, settle count
    ST_MEAS,       // gate window running, resets asserted
    ST_DECIDE,     // compare with committed settings
    ST_PLL_REQ,    // clock generator request held
    ST_LANE_REQ,   // lane request held
    ST_HOLD2,      // resets asserted after programming
    ST_LOCK_WAIT,  // resets released, waiting for locks
    ST_RUN,        // steady state
    ST_REMEAS      // periodic measurement in steady state
  } seq_state_e;

  // Clock generator needs new settings when nothing is stored yet,
  // or when either the band or the depth moved.
  function automatic logic want_pll(input logic have_prev,
                                    input logic band_moved,
                                    input logic depth_moved);
    return !have_prev || band_moved || depth_moved;
  endfunction

  // Lane settings follow the band only.
  function automatic logic want_lane(input logic have_prev,
                                     input logic band_moved);
    return !have_prev || band_moved;
  endfunction

  // Bands below the slow limit need oversampling.
  function automatic logic is_slow(input int unsigned band,
                                   input int unsigned slow_bands);
    return band < slow_bands;
  endfunction

endpackage

// File: rtl/rrs_edge_meter.sv
module rrs_edge_meter #(
  parameter int unsigned GATE_CYCLES = 256,
  localparam int unsigned CW = $clog2(GATE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_clk,
  input  logic          start,
  output logic          done,
  output logic [CW-1:0] edges
);
  localparam logic [CW-1:0] GATE_LAST = CW'(GATE_CYCLES - 1);

  logic [2:0]    sync_q;
  logic          busy_q;
  logic [CW-1:0] gate_q;
  logic          rise;

  // Two stages to settle the asynchronous clock, a third for the edge
  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      busy_q <= 1'b0;
      gate_q <= '0;
      edges  <= '0;
      done   <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], meas_clk};
      done   <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        gate_q <= '0;
        edges  <= '0;
      end else if (busy_q) begin
        if (rise) edges <= edges + 1'b1;
        if (gate_q == GATE_LAST) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end else begin
          gate_q <= gate_q + 1'b1;
        end
      end
    end
  end

  // R3: a finished window is reported for exactly one cycle
  p_gate_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: a measurement cannot finish in the cycle right after it starts
  p_gate_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

endmodule

// File: rtl/rrs_band_map.sv
module rrs_band_map #(
  parameter int unsigned NBANDS = 4,
  parameter int unsigned CW = 9,
  parameter logic [(NBANDS-1)*32-1:0] BAND_EDGES = {32'd94, 32'd67, 32'd40},
  localparam int unsigned BW = (NBANDS > 1) ? $clog2(NBANDS) : 1
) (
  input  logic [CW-1:0] count,
  output logic [BW-1:0] band
);
  logic [NBANDS-2:0] above;

  for (genvar i = 0; i < NBANDS - 1; i++) begin : g_edge
    assign above[i] = (32'(count) >= BAND_EDGES[i*32 +: 32]);
  end

  always_comb begin
    band = '0;
    for (int i = 0; i < NBANDS - 1; i++) band = band + BW'(above[i]);
  end

endmodule

// File: rtl/rrs_seq_ctrl.sv
module rrs_seq_ctrl
  import rrs_pkg::*;
#(
  parameter int unsigned BW           = 2,
  parameter int unsigned DEPTH_W      = 2,
  parameter int unsigned RST_CYCLES   = 8,
  parameter int unsigned TIMEOUT      = 1024,
  parameter int unsigned OVS_BANDS    = 1,
  parameter int unsigned RUN_INTERVAL = 4096,
  localparam int unsigned WMAX = (TIMEOUT > RST_CYCLES) ? TIMEOUT : RST_CYCLES,
  localparam int unsigned WW   = $clog2(WMAX + 1),
  localparam int unsigned IW   = $clog2(RUN_INTERVAL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               all_locked,
  input  logic [DEPTH_W-1:0] depth_in,
  input  logic [BW-1:0]      meas_band,
  input  logic               meas_done,
  output logic               meas_start,
  input  logic               pll_ack,
  input  logic               lane_ack,
  output logic               pll_req,
  output logic               lane_req,
  output logic               pll_rst,
  output logic               lane_rst,
  output logic [BW-1:0]      cfg_band,
  output logic [DEPTH_W-1:0] cfg_depth,
  output logic               oversample
);
  localparam logic [WW-1:0] RST_LAST = WW'(RST_CYCLES - 1);
  localparam logic [WW-1:0] TMO_LAST = WW'(TIMEOUT - 1);
  localparam logic [IW-1:0] IVL_LAST = IW'(RUN_INTERVAL - 1);

  seq_state_e         state_q, state_d;
  logic [WW-1:0]      wait_q;
  logic [IW-1:0]      ivl_q;
  logic [BW-1:0]      new_band_q;
  logic               have_prev_q, lane_todo_q;

  // Named events for the assertions and the decision
  logic hold_done, tmo, ivl_tick, in_run, band_moved, depth_moved;
  logic pll_need, lane_need, give_up;

  assign hold_done   = (wait_q == RST_LAST);
  assign tmo         = (wait_q == TMO_LAST);
  assign ivl_tick    = (ivl_q == IVL_LAST);
  assign in_run      = (state_q == ST_RUN) || (state_q == ST_REMEAS);
  assign band_moved  = (new_band_q != cfg_band);
  assign depth_moved = (depth_in != cfg_depth);
  assign pll_need    = want_pll(have_prev_q, band_moved, depth_moved);
  assign lane_need   = want_lane(have_prev_q, band_moved);

  always_comb begin
    state_d    = state_q;
    meas_start = 1'b0;
    give_up    = 1'b0;
    unique case (state_q)
      ST_HOLD: if (hold_done) begin
        state_d    = ST_MEAS;
        meas_start = 1'b1;
      end
      ST_MEAS: if (meas_done) state_d = ST_DECIDE;
      ST_DECIDE: begin
        if (pll_need)       state_d = ST_PLL_REQ;
        else if (lane_need) state_d = ST_LANE_REQ;
        else                state_d = ST_HOLD2;
      end
      ST_PLL_REQ: begin
        if (pll_ack)  state_d = lane_todo_q ? ST_LANE_REQ : ST_HOLD2;
        else if (tmo) begin state_d = ST_HOLD; give_up = 1'b1; end
      end
      ST_LANE_REQ: begin
        if (lane_ack) state_d = ST_HOLD2;
        else if (tmo) begin state_d = ST_HOLD; give_up = 1'b1; end
      end
      ST_HOLD2: if (hold_done) state_d = ST_LOCK_WAIT;
      ST_LOCK_WAIT: begin
        if (all_locked) state_d = ST_RUN;
        else if (tmo)   begin state_d = ST_HOLD; give_up = 1'b1; end
      end
      ST_RUN: begin
        if (!all_locked) state_d = ST_HOLD;
        else if (ivl_tick) begin
          state_d    = ST_REMEAS;
          meas_start = 1'b1;
        end
      end
      ST_REMEAS: begin
        if (!all_locked)    state_d = ST_HOLD;
        else if (meas_done) state_d = (meas_band != cfg_band) ? ST_HOLD : ST_RUN;
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_HOLD;
      wait_q      <= '0;
      ivl_q       <= '0;
      new_band_q  <= '0;
      have_prev_q <= 1'b0;
      lane_todo_q <= 1'b0;
      cfg_band    <= '0;
      cfg_depth   <= '0;
      oversample  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= (state_d != state_q) ? '0 : wait_q + 1'b1;
      ivl_q   <= ivl_tick ? '0 : ivl_q + 1'b1;
      if (state_q == ST_MEAS && meas_done) new_band_q <= meas_band;
      if (state_q == ST_DECIDE) begin
        cfg_band    <= new_band_q;
        cfg_depth   <= depth_in;
        have_prev_q <= 1'b1;
        lane_todo_q <= lane_need;
        oversample  <= is_slow(32'(new_band_q), OVS_BANDS);
      end
      if (give_up) have_prev_q <= 1'b0;
    end
  end

  assign pll_req  = (state_q == ST_PLL_REQ);
  assign lane_req = (state_q == ST_LANE_REQ);
  assign pll_rst  = !(in_run || state_q == ST_LOCK_WAIT);
  assign lane_rst = pll_rst;

  // R2: requests only while both resets are held
  p_req_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_req || lane_req) |-> (pll_rst && lane_rst));

  // R7: a request is held until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_req && !pll_ack && !tmo) |=> pll_req);

  // R7: a request drops right after its acknowledge
  p_req_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_req && lane_ack) |=> !lane_req);

  // R8: an unanswered request gives up and stays in reset
  p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_req && tmo && !pll_ack) |=> (!pll_req && pll_rst));

  // R9: resets are released together
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst) |-> $fell(lane_rst));

  // R10: loss of lock in steady state restarts at once
  p_loss_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !all_locked) |=> (pll_rst && lane_rst));

  // R12: oversampling select never moves while the lane runs
  p_ovs_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oversample) |-> pll_rst);

endmodule

// File: rtl/rate_reconfig_seq.sv
module rate_reconfig_seq #(
  parameter int unsigned GATE_CYCLES  = 256,
  parameter int unsigned NBANDS       = 4,
  parameter logic [(NBANDS-1)*32-1:0] BAND_EDGES = {32'd94, 32'd67, 32'd40},
  parameter int unsigned OVS_BANDS    = 1,
  parameter int unsigned DEPTH_W      = 2,
  parameter int unsigned RST_CYCLES   = 8,
  parameter int unsigned TIMEOUT      = 1024,
  parameter int unsigned RUN_INTERVAL = 4096,
  localparam int unsigned BW = (NBANDS > 1) ? $clog2(NBANDS) : 1
) (
  input  logic               clk_mgmt,
  input  logic               rst_mgmt_n,
  input  logic               link_clk,
  input  logic               pll_locked,
  input  logic               lane_locked,
  input  logic               core_locked,
  input  logic [DEPTH_W-1:0] color_depth,
  output logic               pll_cfg_req,
  input  logic               pll_cfg_ack,
  output logic               lane_cfg_req,
  input  logic               lane_cfg_ack,
  output logic               pll_rst,
  output logic               lane_rst,
  output logic [BW-1:0]      cfg_band,
  output logic [DEPTH_W-1:0] cfg_depth,
  output logic               oversample_en
);
  localparam int unsigned CW = $clog2(GATE_CYCLES + 1);

  logic          meas_start, meas_done, all_locked;
  logic [CW-1:0] edge_count;
  logic [BW-1:0] meas_band;

  assign all_locked = pll_locked & lane_locked & core_locked;

  rrs_edge_meter #(.GATE_CYCLES(GATE_CYCLES)) u_meter (
    .clk      (clk_mgmt),
    .rst_n    (rst_mgmt_n),
    .meas_clk (link_clk),
    .start    (meas_start),
    .done     (meas_done),
    .edges    (edge_count)
  );

  rrs_band_map #(.NBANDS(NBANDS), .CW(CW), .BAND_EDGES(BAND_EDGES)) u_map (
    .count (edge_count),
    .band  (meas_band)
  );

  rrs_seq_ctrl #(
    .BW(BW), .DEPTH_W(DEPTH_W), .RST_CYCLES(RST_CYCLES), .TIMEOUT(TIMEOUT),
    .OVS_BANDS(OVS_BANDS), .RUN_INTERVAL(RUN_INTERVAL)
  ) u_ctrl (
    .clk        (clk_mgmt),
    .rst_n      (rst_mgmt_n),
    .all_locked (all_locked),
    .depth_in   (color_depth),
    .meas_band  (meas_band),
    .meas_done  (meas_done),
    .meas_start (meas_start),
    .pll_ack    (pll_cfg_ack),
    .lane_ack   (lane_cfg_ack),
    .pll_req    (pll_cfg_req),
    .lane_req   (lane_cfg_req),
    .pll_rst    (pll_rst),
    .lane_rst   (lane_rst),
    .cfg_band   (cfg_band),
    .cfg_depth  (cfg_depth),
    .oversample (oversample_en)
  );

endmodule

// File: tb/rate_reconfig_seq_bench.sv
`timescale 1ns/100ps
module rate_reconfig_seq_bench;
  localparam int TMO = 200;
  localparam int IVL = 1500;
  localparam int HOLD = 8;

  logic clk = 1'b0, rst_n = 1'b0, link_clk = 1'b0;
  logic pll_locked = 1'b1, lane_locked = 1'b1, core_locked = 1'b1;
  logic [1:0] depth = 2'd0;
  logic pll_ack = 1'b0, lane_ack = 1'b0;
  logic pll_req, lane_req, pll_rst, lane_rst, ovs;
  logic [1:0] cfg_band, cfg_depth;
  int link_half = 25;
  int n_chk = 0, n_bad = 0;
  bit no_ack = 0, finished = 0;

  always #2.5 clk = ~clk;
  always begin #(link_half) link_clk = ~link_clk; end

  rate_reconfig_seq #(.TIMEOUT(TMO), .RUN_INTERVAL(IVL), .RST_CYCLES(HOLD)) u_rate_reconfig_seq (
    .clk_mgmt(clk), .rst_mgmt_n(rst_n), .link_clk(link_clk),
    .pll_locked(pll_locked), .lane_locked(lane_locked), .core_locked(core_locked),
    .color_depth(depth), .pll_cfg_req(pll_req), .pll_cfg_ack(pll_ack),
    .lane_cfg_req(lane_req), .lane_cfg_ack(lane_ack), .pll_rst(pll_rst),
    .lane_rst(lane_rst), .cfg_band(cfg_band), .cfg_depth(cfg_depth),
    .oversample_en(ovs));

  // half period (ns), depth, expected band, pll request, lane request, oversampling
  typedef struct packed {
    logic [7:0] half; logic [1:0] dep; logic [1:0] band;
    logic pll; logic lane; logic ov; logic kick;
  } vec_t;
  localparam vec_t VECS [7] = '{
    '{8'd25, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 first pass
    '{8'd25, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1},  // R6 nothing changed
    '{8'd25, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 depth only
    '{8'd12, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1},  // R5 band up
    '{8'd8,  2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1},
    '{8'd8,  2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'd6,  2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_pass(input vec_t v);
    int npll = 0, nlane = 0, tail = 0, age = 0, ack_kind = 0;
    bit prev_p = 0, prev_l = 0, ended = 0;
    if (v.kick) begin
      @(negedge clk) core_locked = 1'b0;
      @(negedge clk) core_locked = 1'b1;
      chk(pll_rst && lane_rst, "R10", "resets after lock loss", int'(pll_rst), 1);
    end
    link_half = int'(v.half);
    depth = v.dep;
    for (int it = 0; it < 6000 && !ended; it++) begin
      @(negedge clk);
      if (ack_kind != 0) begin
        if (ack_kind == 1) chk(!pll_req, "R7", "pll request after ack", int'(pll_req), 0);
        else chk(!lane_req, "R7", "lane request after ack", int'(lane_req), 0);
        ack_kind = 0; pll_ack = 1'b0; lane_ack = 1'b0;
      end
      if (pll_req && !prev_p) begin
        npll++;
        chk(pll_rst && lane_rst, "R2", "resets at pll request", int'(pll_rst & lane_rst), 1);
        chk(nlane == 0, "R5", "pll request before lane", nlane, 0);
      end
      if (lane_req && !prev_l) begin
        nlane++;
        chk(pll_rst && lane_rst, "R2", "resets at lane request", int'(pll_rst & lane_rst), 1);
        chk(!pll_req, "R5", "both requests high", int'(pll_req), 0);
      end
      prev_p = pll_req; prev_l = lane_req;
      if (pll_req || lane_req) begin
        tail = 0; age++;
        if (age == 3 && !no_ack) begin
          if (pll_req) begin pll_ack = 1'b1; ack_kind = 1; end
          else begin lane_ack = 1'b1; ack_kind = 2; end
          age = 0;
        end
      end else if (pll_rst) begin
        tail++;
      end
      if (!pll_rst) ended = 1;
    end
    chk(ended, "R9", "resets released", int'(ended), 1);
    chk(!lane_rst, "R9", "lane reset released with pll reset", int'(lane_rst), 0);
    chk(tail >= HOLD, "R9", "settle cycles before release", tail, HOLD);
    chk(npll == int'(v.pll), "R5", "pll requests in pass", npll, int'(v.pll));
    chk(nlane == int'(v.lane), "R5", "lane requests in pass", nlane, int'(v.lane));
    chk(cfg_band == v.band, "R3", "committed band", int'(cfg_band), int'(v.band));
    chk(cfg_depth == v.dep, "R3", "committed depth", int'(cfg_depth), int'(v.dep));
    chk(ovs == v.ov, "R12", "oversampling select", int'(ovs), int'(v.ov));
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int hi;
    bit seen;
    repeat (3) @(negedge clk);
    chk(pll_rst && lane_rst, "R1", "resets in reset", int'(pll_rst & lane_rst), 1);
    chk(!pll_req && !lane_req, "R1", "requests in reset", int'(pll_req | lane_req), 0);
    chk(!ovs, "R1", "oversampling in reset", int'(ovs), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pll_rst && !pll_req, "R1", "state after reset release", int'(pll_rst), 1);

    for (int i = 0; i < 7; i++) run_pass(VECS[i]);

    // R11: same band through two measurement intervals keeps resets released
    seen = 0;
    for (int i = 0; i < 2 * IVL + 400; i++) begin
      @(negedge clk);
      if (pll_rst) seen = 1;
    end
    chk(!seen, "R11", "restart with unchanged band", int'(seen), 0);

    // R11: band change found by the periodic measurement alone
    link_half = 25;
    seen = 0;
    for (int i = 0; i < IVL + 800 && !seen; i++) begin
      @(negedge clk);
      if (pll_rst) seen = 1;
    end
    chk(seen, "R11", "restart on band change", int'(seen), 1);
    run_pass('{8'd25, 2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0});

    // R8: withheld acknowledge times out
    no_ack = 1;
    @(negedge clk) core_locked = 1'b0;
    @(negedge clk) core_locked = 1'b1;
    link_half = 12;
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (pll_req) seen = 1;
    end
    chk(seen, "R8", "pll request raised", int'(seen), 1);
    hi = 1;
    while (pll_req && hi < 1000) begin
      @(negedge clk);
      if (pll_req) hi++;
    end
    chk(hi >= TMO - 1 && hi <= TMO + 1, "R8", "request high cycles", hi, TMO);
    chk(pll_rst && !pll_req, "R8", "reset held after timeout", int'(pll_rst), 1);
    no_ack = 0;
    // band 1 was already committed before the timeout: both must be requested again
    run_pass('{8'd12, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0});

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule